// File: doc/BRIEF.md
# General-Purpose Register Bank with Observation Taps

This block holds the integer working registers of a small processor core: thirty-two words of thirty-two bits. Two independent read ports return the word chosen by their index with no clock delay, and a single write port stores a word at the rising clock edge when its enable is high. Entry zero is a constant: it reads as zero whatever is written to it, so software can use it as a discard target and a zero source.

Eight entries that a test environment watches most often are also driven, all the time, onto their own output buses. These are the return-address entry (1), the stack-pointer entry (2), the three temporaries (5, 6, 7), the two saved entries (8, 9) and the first argument entry (10). A harness can follow program progress on these buses without using the read ports.

The block has no states beyond its stored words. Reset is synchronous and active low, and it clears every entry. A write reaches the read ports and taps only after the edge that stores it: reads in the same cycle as a write return the old word.

Top module: `gpr_bank_dbg`

## Requirements
- R1: While `rst_n` is low at a rising edge, every entry is cleared to zero; after reset both read ports return zero for all 32 indices and all eight taps show zero.
- R2: When `wr_en` is 1 and `wr_idx` is not 0 at a rising edge, the entry `wr_idx` holds `wr_data` from that edge on.
- R3: When `wr_en` is 0 at a rising edge, no entry changes, whatever `wr_idx` and `wr_data` hold.
- R4: Entry 0 reads as zero on both ports at all times, including after a write with `wr_en` = 1 and `wr_idx` = 0.
- R5: `rd_a_data` shows the entry selected by `rd_a_idx` and `rd_b_data` the entry selected by `rd_b_idx`, the two chosen independently, combinationally, for any index 0 to 31.
- R6: There is no write-to-read forwarding: in the cycle a write is presented, a read of the target index returns the value held before the edge.
- R7: The taps show entries continuously: `tap_ret_addr` = entry 1, `tap_stack_ptr` = 2, `tap_tmp0` = 5, `tap_tmp1` = 6, `tap_tmp2` = 7, `tap_sav0` = 8, `tap_sav1` = 9, `tap_arg0` = 10, each updated at the edge that writes that entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes and reset act on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low; clears all entries |
| rd_a_idx | input | 5 | Index of the entry returned on read port A |
| rd_b_idx | input | 5 | Index of the entry returned on read port B |
| wr_idx | input | 5 | Index of the entry written at the next edge |
| wr_data | input | 32 | Word stored at the next edge |
| wr_en | input | 1 | Write enable, active high |
| rd_a_data | output | 32 | Entry selected by `rd_a_idx` |
| rd_b_data | output | 32 | Entry selected by `rd_b_idx` |
| tap_ret_addr | output | 32 | Entry 1, always driven |
| tap_stack_ptr | output | 32 | Entry 2, always driven |
| tap_tmp0 | output | 32 | Entry 5, always driven |
| tap_tmp1 | output | 32 | Entry 6, always driven |
| tap_tmp2 | output | 32 | Entry 7, always driven |
| tap_sav0 | output | 32 | Entry 8, always driven |
| tap_sav1 | output | 32 | Entry 9, always driven |
| tap_arg0 | output | 32 | Entry 10, always driven |

## Verification
The assertions assume that the write inputs are stable and known across each rising edge and that `rst_n` is held low for at least one edge before use; they are switched off while reset is low, so the clearing itself is checked by the bench at the ports. Stimulus is applied on the falling edge, which keeps every index, data word and enable settled for the full half-cycle before the edge. The random phase draws all indices from the full 0 to 31 range, so index 0 and the tapped entries are hit often, with enable both high and low, and the directed cases add same-cycle read-of-target and the top index.

// File: rtl/gpr_bank_pkg.sv
package gpr_bank_pkg;

    // Number of observation taps and the entry each one follows.
    localparam int TAP_COUNT = 8;

    function automatic int tap_entry(input int slot);
        case (slot)
            0:       return 1;
            1:       return 2;
            2:       return 5;
            3:       return 6;
            4:       return 7;
            5:       return 8;
            6:       return 9;
            default: return 10;
        endcase
    endfunction

endpackage

// File: rtl/gpr_wr_decode.sv
module gpr_wr_decode #(
    parameter int NUM_REGS = 32,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [IDX_W-1:0]    wr_idx,
    output logic [NUM_REGS-1:0] row_we
);

    // One write strobe per entry; row 0 never receives a strobe.
    always_comb begin
        row_we = '0;
        for (int k = 1; k < NUM_REGS; k++) begin
            row_we[k] = wr_en && (wr_idx == IDX_W'(k));
        end
    end

    // R4: the constant row is never strobed
    a_r4_row0_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !row_we[0]);

    // R2: at most one row takes a write per edge
    a_r2_single_row: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(row_we));

    // R3: with the enable low no row is strobed
    a_r3_idle_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |-> (row_we == '0));

endmodule

// File: rtl/gpr_store.sv
module gpr_store #(
    parameter int NUM_REGS = 32,
    parameter int DATA_W   = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_REGS-1:0] row_we,
    input  logic [DATA_W-1:0]   wr_data,
    output logic [DATA_W-1:0]   word_q [NUM_REGS]
);

    for (genvar k = 0; k < NUM_REGS; k++) begin : g_row
        if (k == 0) begin : g_const
            // Entry 0 has no storage.
            assign word_q[k] = '0;
        end else begin : g_flop
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    word_q[k] <= '0;
                end else if (row_we[k]) begin
                    word_q[k] <= wr_data;
                end
            end

            // R2: a strobed row holds the presented word after the edge
            a_r2_row_commit: assert property (@(posedge clk) disable iff (!rst_n)
                row_we[k] |=> (word_q[k] == $past(wr_data)));

            // R3: an unstrobed row keeps its word
            a_r3_row_hold: assert property (@(posedge clk) disable iff (!rst_n)
                !row_we[k] |=> $stable(word_q[k]));
        end
    end

endmodule

// File: rtl/gpr_rd_mux.sv
module gpr_rd_mux #(
    parameter int NUM_REGS = 32,
    parameter int DATA_W   = 32,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [IDX_W-1:0]   sel_idx,
    input  logic [DATA_W-1:0]  word_q [NUM_REGS],
    output logic [DATA_W-1:0]  sel_data
);

    always_comb begin
        sel_data = word_q[sel_idx];
    end

    // R4: index 0 yields zero on this port
    a_r4_zero_read: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_idx == '0) |-> (sel_data == '0));

endmodule

// File: rtl/gpr_bank_dbg.sv
module gpr_bank_dbg
    import gpr_bank_pkg::*;
#(
    parameter int NUM_REGS = 32,
    parameter int DATA_W   = 32,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_a_idx,
    input  logic [IDX_W-1:0]  rd_b_idx,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_en,
    output logic [DATA_W-1:0] rd_a_data,
    output logic [DATA_W-1:0] rd_b_data,
    output logic [DATA_W-1:0] tap_ret_addr,
    output logic [DATA_W-1:0] tap_stack_ptr,
    output logic [DATA_W-1:0] tap_tmp0,
    output logic [DATA_W-1:0] tap_tmp1,
    output logic [DATA_W-1:0] tap_tmp2,
    output logic [DATA_W-1:0] tap_sav0,
    output logic [DATA_W-1:0] tap_sav1,
    output logic [DATA_W-1:0] tap_arg0
);

    logic [NUM_REGS-1:0] row_we;
    logic [DATA_W-1:0]   word_q [NUM_REGS];
    logic [DATA_W-1:0]   tap_vec [TAP_COUNT];

    gpr_wr_decode #(.NUM_REGS(NUM_REGS)) u_dec (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_idx (wr_idx),
        .row_we (row_we)
    );

    gpr_store #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .row_we  (row_we),
        .wr_data (wr_data),
        .word_q  (word_q)
    );

    gpr_rd_mux #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_port_a (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_idx  (rd_a_idx),
        .word_q   (word_q),
        .sel_data (rd_a_data)
    );

    gpr_rd_mux #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_port_b (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_idx  (rd_b_idx),
        .word_q   (word_q),
        .sel_data (rd_b_data)
    );

    for (genvar t = 0; t < TAP_COUNT; t++) begin : g_tap
        localparam int ENTRY = tap_entry(t);
        assign tap_vec[t] = word_q[ENTRY];

        // R7: a write to a tapped entry shows on its tap after the edge
        a_r7_tap_follow: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && (wr_idx == IDX_W'(ENTRY))) |=> (tap_vec[t] == $past(wr_data)));
    end

    assign tap_ret_addr  = tap_vec[0];
    assign tap_stack_ptr = tap_vec[1];
    assign tap_tmp0      = tap_vec[2];
    assign tap_tmp1      = tap_vec[3];
    assign tap_tmp2      = tap_vec[4];
    assign tap_sav0      = tap_vec[5];
    assign tap_sav1      = tap_vec[6];
    assign tap_arg0      = tap_vec[7];

    // R5: a written nonzero entry reads back on port A if the index is held
    a_r5_port_a_readback: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_idx != '0) && (wr_idx == rd_a_idx))
        |=> (!$stable(rd_a_idx) || (rd_a_data == $past(wr_data))));

    // R5: same for port B
    a_r5_port_b_readback: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_idx != '0) && (wr_idx == rd_b_idx))
        |=> (!$stable(rd_b_idx) || (rd_b_data == $past(wr_data))));

endmodule

// File: tb/gpr_bank_dbg_tb.sv
module gpr_bank_dbg_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [4:0]  rd_a_idx, rd_b_idx, wr_idx;
    logic [31:0] wr_data;
    logic        wr_en;
    logic [31:0] rd_a_data, rd_b_data;
    logic [31:0] tap_ret_addr, tap_stack_ptr, tap_tmp0, tap_tmp1;
    logic [31:0] tap_tmp2, tap_sav0, tap_sav1, tap_arg0;

    int n_checks = 0;
    int n_fails  = 0;
    logic [31:0] shadow [32];

    always #5 clk = ~clk;

    gpr_bank_dbg u_dut (
        .clk(clk), .rst_n(rst_n),
        .rd_a_idx(rd_a_idx), .rd_b_idx(rd_b_idx),
        .wr_idx(wr_idx), .wr_data(wr_data), .wr_en(wr_en),
        .rd_a_data(rd_a_data), .rd_b_data(rd_b_data),
        .tap_ret_addr(tap_ret_addr), .tap_stack_ptr(tap_stack_ptr),
        .tap_tmp0(tap_tmp0), .tap_tmp1(tap_tmp1), .tap_tmp2(tap_tmp2),
        .tap_sav0(tap_sav0), .tap_sav1(tap_sav1), .tap_arg0(tap_arg0)
    );

    function automatic logic [31:0] expect_word(input logic [4:0] idx);
        return (idx == 5'd0) ? 32'd0 : shadow[idx];
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic check_taps();
        check("R7", "tap 1",  tap_ret_addr,  expect_word(5'd1));
        check("R7", "tap 2",  tap_stack_ptr, expect_word(5'd2));
        check("R7", "tap 5",  tap_tmp0,      expect_word(5'd5));
        check("R7", "tap 6",  tap_tmp1,      expect_word(5'd6));
        check("R7", "tap 7",  tap_tmp2,      expect_word(5'd7));
        check("R7", "tap 8",  tap_sav0,      expect_word(5'd8));
        check("R7", "tap 9",  tap_sav1,      expect_word(5'd9));
        check("R7", "tap 10", tap_arg0,      expect_word(5'd10));
    endtask

    // Drive on the falling edge, check the combinational reads before the
    // rising edge (old contents, so also no forwarding), then commit.
    task automatic step(input logic we, input logic [4:0] wi, input logic [31:0] wd,
                        input logic [4:0] ra, input logic [4:0] rb, input string req);
        @(negedge clk);
        wr_en = we; wr_idx = wi; wr_data = wd; rd_a_idx = ra; rd_b_idx = rb;
        #1;
        check(req, "port A", rd_a_data, expect_word(ra));
        check(req, "port B", rd_b_data, expect_word(rb));
        check_taps();
        @(posedge clk);
        if (we && wi != 5'd0) shadow[wi] = wd;
    endtask

    initial begin
        #1_000_000;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < 32; i++) shadow[i] = 32'd0;
        rst_n = 1'b0; wr_en = 1'b1; wr_idx = 5'd3; wr_data = 32'hFFFF_FFFF;
        rd_a_idx = 5'd0; rd_b_idx = 5'd0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1; wr_en = 1'b0;

        // R1: everything cleared, including the entry written during reset
        for (int i = 0; i < 32; i++) begin
            step(1'b0, 5'd0, 32'd0, 5'(i), 5'(31 - i), "R1");
        end

        // R2: write then read back on both ports
        step(1'b1, 5'd5, 32'hCAFE_0005, 5'd0, 5'd0, "R2");
        step(1'b0, 5'd0, 32'd0, 5'd5, 5'd5, "R2");
        // R4: write to entry 0 has no effect
        step(1'b1, 5'd0, 32'hDEAD_BEEF, 5'd0, 5'd0, "R4");
        step(1'b0, 5'd0, 32'd0, 5'd0, 5'd0, "R4");
        // R3: enable low leaves entry 7 untouched
        step(1'b0, 5'd7, 32'h1234_5678, 5'd7, 5'd7, "R3");
        step(1'b0, 5'd0, 32'd0, 5'd7, 5'd7, "R3");
        // R5: top index and independent ports
        step(1'b1, 5'd31, 32'h8000_0001, 5'd5, 5'd31, "R5");
        step(1'b0, 5'd0, 32'd0, 5'd31, 5'd5, "R5");
        // R6: same-cycle read of the target shows the old word
        step(1'b1, 5'd31, 32'h0BAD_F00D, 5'd31, 5'd31, "R6");
        step(1'b0, 5'd0, 32'd0, 5'd31, 5'd31, "R6");
        // R7: fill every tapped entry
        for (int i = 1; i <= 10; i++) begin
            step(1'b1, 5'(i), 32'hA000_0000 + 32'(i), 5'(i), 5'd0, "R7");
        end

        // Random mix
        for (int n = 0; n < 3000; n++) begin
            logic        we;
            logic [4:0]  wi, ra, rb;
            logic [31:0] wd;
            we = ($urandom % 4) != 0;
            wi = 5'($urandom % 32);
            wd = $urandom;
            ra = (($urandom % 3) == 0) ? wi : 5'($urandom % 32);
            rb = 5'($urandom % 32);
            step(we, wi, wd, ra, rb, "R5");
        end

        // Final sweep
        for (int i = 0; i < 32; i++) begin
            step(1'b0, 5'(i), 32'hFFFF_FFFF, 5'(i), 5'(i), "R3");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule